// File: doc/BRIEF.md
# Fractional-Correction Baud Tick Generator

This block turns a fast system clock into the clock-enable pulses that time two serial links. One is a UART running at 16x oversampling. The other is an infrared SIR channel whose reference tick sits near 1.8432 MHz. Each channel has an integer divisor and a 4-bit correction index worth sixteenths of a system clock. A 4-bit phase accumulator absorbs the fraction: each time the index is added, a carry out of the accumulator stretches that interval by one system clock. The average period therefore lands exactly on the integer plus index/16.

Software writes four 8-bit fields through a single write strobe, and the select code picks the field. Any write to a channel's field restarts that channel: its counter and accumulator go back to zero, so the new rate starts on a clean boundary. The UART channel emits an oversample tick, plus a bit tick on every sixteenth oversample tick. Its correction is applied once per bit, on the last oversample interval. The SIR channel applies its correction on every interval. A SIR count of zero is illegal: the block raises an error flag and holds the SIR tick low.

Each channel is driven by a small state machine with three states. HALT means the channel is stopped. COUNT walks the counter from zero up to the programmed count. PAD is the single extra clock inserted when the accumulator carries. The transitions are: HALT to COUNT when the channel becomes runnable; COUNT to COUNT at the end of an interval with no carry; COUNT to PAD at the end of an interval that carries; PAD to COUNT once the extra clock is done; COUNT or PAD to HALT when the channel stops being runnable. A restart always enters COUNT with the counter and accumulator cleared.

Top module: `fracbaud_gen`

## Requirements
- R1: With UART count field C (wr_sel 0, bits UCNT_W-1:0) and correction index n (wr_sel 1, bits 7:4), any 16 consecutive bit periods total exactly 256*(C+1)+n system clocks.
- R2: Each UART bit period contains exactly 16 oversample ticks. The bit tick is asserted only in a cycle where the oversample tick is also asserted.
- R3: With SIR count field K from 1 to 15 (wr_sel 2, bits 3:0) and index n (wr_sel 3, bits 7:4), any 16 consecutive SIR tick periods total exactly 16*(K+1)+n system clocks.
- R4: While the SIR count field is zero, sir_cnt_err is 1 and sir_tick stays 0. A nonzero field clears sir_cnt_err in the cycle after the write.
- R5: Bits 3:0 of a correction write are ignored. Only bits 7:4 select the sixteenths index.
- R6: A write to either field of a channel restarts that channel. After the write edge, the first SIR tick appears K+1 cycles later, the first UART oversample tick C+1 cycles later, and the first bit tick 16*(C+1) cycles later. No SIR tick occurs in the cycle right after a SIR write.
- R7: sir_tick and uart_bit_tick are single-cycle pulses and are never high in two adjacent cycles.
- R8: After reset, both count and correction fields are zero, sir_cnt_err is 1 and sir_tick is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 2 | Field select: 0 UART count, 1 UART correction, 2 SIR count, 3 SIR correction |
| wr_data | input | DATA_W | Write data; the correction index is in bits 7:4 |
| uart_os_tick | output | 1 | UART 16x oversample enable pulse |
| uart_bit_tick | output | 1 | UART bit enable pulse, once per 16 oversample ticks |
| sir_tick | output | 1 | SIR reference enable pulse |
| sir_cnt_err | output | 1 | SIR count field is zero (illegal) |

## Verification
The bench uses the default parameters: an 8-bit UART count and 8-bit write data. Restricting the UART count to 0 through 2 keeps each bit period short. This lets the bench cover all sixteen correction indices against every small UART count, and every legal SIR count against all sixteen indices, each measured over sixteen periods. With those short periods, the longest-count, highest-index stretch patterns and the divide-by-one oversample case all fit inside the run.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;

    localparam int CORR_W    = 4;
    localparam int CORR_LSB  = 4;
    localparam int SIR_CNT_W = 4;
    localparam int SUBTICKS  = 16;

    typedef enum logic [1:0] {
        SEL_UART_CNT  = 2'd0,
        SEL_UART_CORR = 2'd1,
        SEL_SIR_CNT   = 2'd2,
        SEL_SIR_CORR  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DIV_HALT  = 2'd0,
        DIV_COUNT = 2'd1,
        DIV_PAD   = 2'd2
    } div_state_e;

endpackage

// File: rtl/fracbaud_div.sv
module fracbaud_div
    import fracbaud_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run_en,
    input  logic [CNT_W-1:0]  base,
    input  logic [CORR_W-1:0] corr,
    input  logic              frac_en,
    output logic              tick
);

    div_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CORR_W-1:0] acc_q, acc_d;
    logic [CORR_W:0]   sum;
    logic              at_end;
    logic              carry;

    always_comb begin
        sum    = {1'b0, acc_q} + {1'b0, corr};
        at_end = (cnt_q == base);
        carry  = frac_en && sum[CORR_W];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        if (restart) begin
            state_d = DIV_COUNT;
            cnt_d   = '0;
            acc_d   = '0;
        end else begin
            unique case (state_q)
                DIV_HALT: begin
                    if (run_en) begin
                        state_d = DIV_COUNT;
                        cnt_d   = '0;
                    end
                end
                DIV_COUNT: begin
                    if (!run_en) begin
                        state_d = DIV_HALT;
                    end else if (at_end) begin
                        cnt_d = '0;
                        if (frac_en) begin
                            acc_d = sum[CORR_W-1:0];
                        end
                        state_d = carry ? DIV_PAD : DIV_COUNT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                DIV_PAD: begin
                    state_d = run_en ? DIV_COUNT : DIV_HALT;
                end
                default: state_d = DIV_HALT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_HALT;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
        end
    end

    // outputs
    always_comb begin
        tick = run_en &&
               (((state_q == DIV_COUNT) && at_end && !carry) ||
                (state_q == DIV_PAD));
    end

endmodule

// File: rtl/fracbaud_uart.sv
module fracbaud_uart
    import fracbaud_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CNT_W-1:0]  count,
    input  logic [CORR_W-1:0] corr,
    output logic              os_tick,
    output logic              bit_tick
);

    localparam int IDX_W = $clog2(SUBTICKS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SUBTICKS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             last_sub;

    assign last_sub = (idx_q == LAST_IDX);

    fracbaud_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run_en  (1'b1),
        .base    (count),
        .corr    (corr),
        .frac_en (last_sub),
        .tick    (os_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (os_tick) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_tick = os_tick && last_sub;

endmodule

// File: rtl/fracbaud_sir.sv
module fracbaud_sir
    import fracbaud_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [SIR_CNT_W-1:0] count,
    input  logic [CORR_W-1:0]    corr,
    output logic                 tick,
    output logic                 cnt_err
);

    assign cnt_err = (count == '0);

    fracbaud_div #(.CNT_W(SIR_CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run_en  (!cnt_err),
        .base    (count),
        .corr    (corr),
        .frac_en (1'b1),
        .tick    (tick)
    );

endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen
    import fracbaud_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int UCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              uart_os_tick,
    output logic              uart_bit_tick,
    output logic              sir_tick,
    output logic              sir_cnt_err
);

    localparam int CORR_MSB = CORR_LSB + CORR_W - 1;

    reg_sel_e              sel;
    logic [UCNT_W-1:0]     uart_cnt_q;
    logic [CORR_W-1:0]     uart_corr_q;
    logic [SIR_CNT_W-1:0]  sir_cnt_q;
    logic [CORR_W-1:0]     sir_corr_q;
    logic                  uart_restart;
    logic                  sir_restart;

    assign sel          = reg_sel_e'(wr_sel);
    assign uart_restart = wr_en && ((sel == SEL_UART_CNT) || (sel == SEL_UART_CORR));
    assign sir_restart  = wr_en && ((sel == SEL_SIR_CNT)  || (sel == SEL_SIR_CORR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uart_cnt_q  <= '0;
            uart_corr_q <= '0;
            sir_cnt_q   <= '0;
            sir_corr_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_UART_CNT:  uart_cnt_q  <= wr_data[UCNT_W-1:0];
                SEL_UART_CORR: uart_corr_q <= wr_data[CORR_MSB:CORR_LSB];
                SEL_SIR_CNT:   sir_cnt_q   <= wr_data[SIR_CNT_W-1:0];
                SEL_SIR_CORR:  sir_corr_q  <= wr_data[CORR_MSB:CORR_LSB];
                default: ;
            endcase
        end
    end

    fracbaud_uart #(.CNT_W(UCNT_W)) u_uart (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (uart_restart),
        .count    (uart_cnt_q),
        .corr     (uart_corr_q),
        .os_tick  (uart_os_tick),
        .bit_tick (uart_bit_tick)
    );

    fracbaud_sir u_sir (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sir_restart),
        .count   (sir_cnt_q),
        .corr    (sir_corr_q),
        .tick    (sir_tick),
        .cnt_err (sir_cnt_err)
    );

endmodule

// File: rtl/fracbaud_gen_chk.sv
module fracbaud_gen_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              uart_os_tick,
    input logic              uart_bit_tick,
    input logic              sir_tick,
    input logic              sir_cnt_err
);

    // R2
    bit_in_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_bit_tick |-> uart_os_tick);

    // R4
    err_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sir_cnt_err |-> !sir_tick);

    // R4
    err_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_sel == 2'd2)) |->
            (sir_cnt_err == ($past(wr_data[3:0]) == 4'd0)));

    // R6
    sir_restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_sel[1]) |-> !sir_tick);

    // R7
    sir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sir_tick |=> !sir_tick);

    // R7
    bit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uart_bit_tick |=> !uart_bit_tick);

endmodule

bind fracbaud_gen fracbaud_gen_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fracbaud_gen_bench.sv
module fracbaud_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       uart_os_tick, uart_bit_tick, sir_tick, sir_cnt_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fracbaud_gen u_fracbaud_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .uart_os_tick  (uart_os_tick),
        .uart_bit_tick (uart_bit_tick),
        .sir_tick      (sir_tick),
        .sir_cnt_err   (sir_cnt_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic meas_uart(output int cyc, output int os, output int dbl);
        int bits = 0;
        bit prev = 1'b0;
        cyc = 0; os = 0; dbl = 0;
        while (!uart_bit_tick) @(negedge clk);
        prev = 1'b1;
        while (bits < 16) begin
            @(negedge clk);
            cyc++;
            if (uart_os_tick) os++;
            if (uart_bit_tick) begin
                bits++;
                if (prev) dbl++;
            end
            prev = uart_bit_tick;
        end
    endtask

    task automatic meas_sir(output int cyc, output int dbl);
        int per = 0;
        bit prev = 1'b0;
        cyc = 0; dbl = 0;
        while (!sir_tick) @(negedge clk);
        prev = 1'b1;
        while (per < 16) begin
            @(negedge clk);
            cyc++;
            if (sir_tick) begin
                per++;
                if (prev) dbl++;
            end
            prev = sir_tick;
        end
    endtask

    task automatic run_main();
        int cyc, os, dbl, cnt, at_os, at_bit, at_sir;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(sir_cnt_err == 1'b1, "R8 err flag after reset", sir_cnt_err, 1);
        chk(sir_tick == 1'b0, "R8 sir tick after reset", sir_tick, 0);
        cnt = 0;
        repeat (40) begin @(negedge clk); if (sir_tick) cnt++; end
        chk(cnt == 0, "R8 no sir ticks after reset", cnt, 0);

        // R6 SIR restart timing
        wr(2'd2, 8'd5);
        wr(2'd3, 8'h00);
        at_sir = 1;
        while (!sir_tick && at_sir < 100) begin @(negedge clk); at_sir++; end
        chk(at_sir == 6, "R6 first sir tick after write", at_sir, 6);
        chk(sir_cnt_err == 1'b0, "R4 err clears on nonzero count", sir_cnt_err, 0);

        // R6 UART restart timing
        wr(2'd0, 8'd2);
        wr(2'd1, 8'h70);
        at_os = 0; at_bit = 0;
        for (int i = 1; i < 200 && at_bit == 0; i++) begin
            if (uart_os_tick && at_os == 0) at_os = i;
            if (uart_bit_tick) at_bit = i;
            @(negedge clk);
        end
        chk(at_os == 3, "R6 first os tick after write", at_os, 3);
        chk(at_bit == 48, "R6 first bit tick after write", at_bit, 48);

        // R1 R2 R7 UART sweep
        for (int c = 0; c < 3; c++) begin
            for (int n = 0; n < 16; n++) begin
                wr(2'd0, 8'(c));
                wr(2'd1, 8'(n << 4));
                meas_uart(cyc, os, dbl);
                chk(cyc == 256 * (c + 1) + n, $sformatf("R1 uart c=%0d n=%0d", c, n), cyc, 256 * (c + 1) + n);
                chk(os == 256, $sformatf("R2 os ticks c=%0d n=%0d", c, n), os, 256);
                chk(dbl == 0, "R7 bit tick adjacency", dbl, 0);
            end
        end

        // R3 R7 SIR sweep
        for (int k = 1; k < 16; k++) begin
            for (int n = 0; n < 16; n++) begin
                wr(2'd2, 8'(k));
                wr(2'd3, 8'(n << 4));
                meas_sir(cyc, dbl);
                chk(cyc == 16 * (k + 1) + n, $sformatf("R3 sir k=%0d n=%0d", k, n), cyc, 16 * (k + 1) + n);
                chk(dbl == 0, "R7 sir tick adjacency", dbl, 0);
            end
        end

        // R5 low correction bits ignored
        wr(2'd2, 8'd3);
        wr(2'd3, 8'h5A);
        meas_sir(cyc, dbl);
        chk(cyc == 69, "R5 sir low bits ignored", cyc, 69);
        wr(2'd0, 8'd1);
        wr(2'd1, 8'h9F);
        meas_uart(cyc, os, dbl);
        chk(cyc == 521, "R5 uart low bits ignored", cyc, 521);

        // R4 illegal SIR count
        wr(2'd2, 8'd0);
        chk(sir_cnt_err == 1'b1, "R4 err on zero count", sir_cnt_err, 1);
        cnt = 0;
        repeat (200) begin @(negedge clk); if (sir_tick) cnt++; end
        chk(cnt == 0, "R4 sir tick held low", cnt, 0);
        wr(2'd2, 8'd4);
        chk(sir_cnt_err == 1'b0, "R4 err clears", sir_cnt_err, 0);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (195000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule